// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Core

This block is a synchronous crosspoint that routes 64 single-bit data inputs onto 33 single-bit data outputs. Every output has its own 64:1 selector, so any pattern of connections can be set up: one input may feed many outputs at the same time (broadcast or multicast), and no connection ever blocks another. Outputs 0 to 31 are the regular ports. Output 32 is a monitor port with its own write strobe.

Each output keeps two 6-bit selections. The pending selection is written by address strobes and has no effect on the data path. The active selection drives the selector. A configure strobe copies all 33 pending selections into the active set in one cycle. Software can therefore stage any number of changes and then switch them over together.

Reset forces every output onto input 0. The first configure after reset is released, if no write strobe comes before it, loads a pass-through map instead. The top input-address bit chooses the lower or the upper half of the inputs for outputs 0 to 31.

Top module: `xbar_dbuf_core`

## Requirements
- R1: Each output `dout[o]` equals `din[s]`, where `s` is the active selection of output `o`. Any number of outputs may hold the same selection, and each routes that input.
- R2: `out_addr` (5 bits, binary) names regular output 0 to 31. `in_addr` (6 bits, binary) names input 0 to 63.
- R3: On each clock edge at which `load` is high, the pending selection of output `out_addr` takes `in_addr`. After `load` falls, that pending value is held unchanged.
- R4: Writes to pending selections do not change any output while `cfg` stays low.
- R5: On each clock edge at which `cfg` is high, all 33 active selections take the pending values, including any write made at that same edge. The new routing shows from that edge onward and is kept after `cfg` falls.
- R6: When `load` and `cfg` are high at the same edge, the newly written selection is routed from that edge onward.
- R7: On each edge at which `mon_load` is high, the pending selection of output 32 takes `in_addr`. `out_addr` and `load` play no part in this write. Output 32 changes only on a later `cfg`.
- R8: At every edge at which `rst` is high, all active and pending selections become 0, so every output carries `din[0]`. This holds for as long as `rst` stays high, whatever the other strobes do.
- R9: The first `cfg` edge after `rst` is released, with `load` and `mon_load` low and no write strobe since the release, applies pass-through. For o < 32, output o selects input o when `in_addr[5]`=0, or input o+32 when `in_addr[5]`=1. Output 32 selects input 0. The same map is stored as the pending selections.
- R10: Once `load` or `mon_load` has been high at any edge after reset, or once a `cfg` edge has passed, pass-through is disarmed. From then on, `cfg` performs the normal copy of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Active-high synchronous reset; broadcast of input 0 |
| load | input | 1 | Write strobe for the pending selection of a regular output |
| mon_load | input | 1 | Write strobe for the pending selection of the monitor output |
| cfg | input | 1 | Copies pending selections into the active set |
| in_addr | input | 6 | Input index to write; bit 5 chooses the pass-through half |
| out_addr | input | 5 | Regular output index for `load` |
| din | input | 64 | Data inputs |
| dout | output | 33 | Data outputs; bit 32 is the monitor port |

## Verification
Routing is combinational from `din` through the active selections. A change of `din` therefore shows on `dout` in the same cycle. A strobe sampled at a rising edge changes the routing just after that edge. The bench applies stimulus at the falling edge and compares all 33 outputs a quarter period later. It updates its behavioural model of the pending and active selections only after the rising edge, so each comparison covers the strobes of the previous edge and the `din` of the current cycle. Directed phases cover reset broadcast, both pass-through halves, disarming by a write, staged writes without configure, combined load and configure, and monitor writes with a misleading output address. A random phase then mixes all strobes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int unsigned N_IN    = 64;
    localparam int unsigned N_OUT   = 32;
    localparam int unsigned N_PORTS = N_OUT + 1;
    localparam int unsigned IAW     = $clog2(N_IN);
    localparam int unsigned OAW     = $clog2(N_OUT);
    localparam int unsigned PW      = $clog2(N_PORTS);
    localparam int unsigned MON     = N_OUT;

    typedef logic [IAW-1:0]         sel_t;
    typedef sel_t [N_PORTS-1:0]     sel_vec_t;
endpackage

// File: rtl/xbar_prog_bank.sv
// Pending (first-stage) selections for all outputs.
module xbar_prog_bank
    import xbar_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            mon_wr,
    input  logic            pt_en,
    input  logic [IAW-1:0]  in_addr,
    input  logic [OAW-1:0]  out_addr,
    output sel_vec_t        prog_nxt,
    output sel_vec_t        prog_cur
);
    typedef struct packed {
        sel_vec_t prog;
    } bank_s;

    bank_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en)
            s_d.prog[PW'(out_addr)] = in_addr;
        if (mon_wr)
            s_d.prog[MON] = in_addr;
        if (pt_en) begin
            for (int o = 0; o < int'(N_OUT); o++)
                s_d.prog[o] = sel_t'(o + (in_addr[IAW-1] ? int'(N_OUT) : 0));
            s_d.prog[MON] = '0;
        end
        if (rst)
            s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign prog_nxt = s_d.prog;
    assign prog_cur = s_q.prog;

    // R3: with no write strobe the pending values stay put
    p_prog_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !mon_wr && !pt_en) |=> $stable(prog_cur))
        else $error("pending selection changed without a write");
endmodule

// File: rtl/xbar_route.sv
// One independent input selector per output.
module xbar_route
    import xbar_pkg::*;
(
    input  sel_vec_t            sel,
    input  logic [N_IN-1:0]     din,
    output logic [N_PORTS-1:0]  dout
);
    for (genvar g = 0; g < int'(N_PORTS); g++) begin : g_port
        assign dout[g] = din[sel[g]];
    end
endmodule

// File: rtl/xbar_dbuf_core.sv
module xbar_dbuf_core
    import xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                mon_load,
    input  logic                cfg,
    input  logic [IAW-1:0]      in_addr,
    input  logic [OAW-1:0]      out_addr,
    input  logic [N_IN-1:0]     din,
    output logic [N_PORTS-1:0]  dout
);
    typedef struct packed {
        logic     armed;
        sel_vec_t act;
    } core_s;

    core_s    s_d, s_q;
    sel_vec_t prog_nxt, prog_cur;
    logic     pt_en;

    assign pt_en = s_q.armed & cfg & ~load & ~mon_load & ~rst;

    xbar_prog_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (load),
        .mon_wr   (mon_load),
        .pt_en    (pt_en),
        .in_addr  (in_addr),
        .out_addr (out_addr),
        .prog_nxt (prog_nxt),
        .prog_cur (prog_cur)
    );

    always_comb begin
        s_d = s_q;
        if (load || mon_load || cfg)
            s_d.armed = 1'b0;
        if (cfg)
            s_d.act = prog_nxt;
        if (rst) begin
            s_d.act   = '0;
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    xbar_route u_route (
        .sel  (s_q.act),
        .din  (din),
        .dout (dout)
    );

    // R4: active routing only moves on configure
    p_no_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg |=> $stable(s_q.act))
        else $error("active selection moved without configure");

    // R5: a plain configure leaves active equal to pending
    p_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg && !load && !mon_load && !pt_en) |=> (s_q.act == prog_cur))
        else $error("configure did not copy pending selections");

    // R9: pass-through puts the monitor on input 0 and uses the chosen half
    p_pass_mon_r9: assert property (@(posedge clk) disable iff (rst)
        pt_en |=> (s_q.act[MON] == '0) && (s_q.act[0][IAW-1] == $past(in_addr[IAW-1])))
        else $error("pass-through map wrong");

    // R10: any write strobe disarms pass-through
    p_disarm_r10: assert property (@(posedge clk) disable iff (rst)
        (load || mon_load) |=> !s_q.armed)
        else $error("pass-through still armed after a write");
endmodule

// File: tb/xbar_dbuf_core_test.sv
module xbar_dbuf_core_test;
    localparam int PERIOD = 10;
    localparam int NI = 64;
    localparam int NO = 32;
    localparam int NP = NO + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic          mon_load = 1'b0;
    logic          cfg = 1'b0;
    logic [5:0]    in_addr = '0;
    logic [4:0]    out_addr = '0;
    logic [NI-1:0] din = '0;
    logic [NP-1:0] dout;

    int checks = 0;
    int fails  = 0;
    int ref_prog [NP];
    int ref_act  [NP];
    bit ref_armed = 1'b1;
    bit chk_on = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    xbar_dbuf_core uut (
        .clk(clk), .rst(rst), .load(load), .mon_load(mon_load), .cfg(cfg),
        .in_addr(in_addr), .out_addr(out_addr), .din(din), .dout(dout)
    );

    task automatic model_edge(input bit r, l, m, c, input int ia, oa);
        bit pt;
        if (r) begin
            for (int o = 0; o < NP; o++) begin ref_prog[o] = 0; ref_act[o] = 0; end
            ref_armed = 1'b1;
        end else begin
            pt = ref_armed && c && !l && !m;
            if (l) ref_prog[oa] = ia;
            if (m) ref_prog[NO] = ia;
            if (pt) begin
                for (int o = 0; o < NO; o++) ref_prog[o] = o + ((ia >= 32) ? 32 : 0);
                ref_prog[NO] = 0;
            end
            if (c) for (int o = 0; o < NP; o++) ref_act[o] = ref_prog[o];
            if (l || m || c) ref_armed = 1'b0;
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit r, l, m, c, input int ia, oa, input string tag);
        logic [NP-1:0] exp;
        rst = r; load = l; mon_load = m; cfg = c;
        in_addr = 6'(ia); out_addr = 5'(oa);
        din = {$urandom, $urandom};
        #(PERIOD/4);
        if (chk_on) begin
            for (int o = 0; o < NP; o++) exp[o] = din[ref_act[o]];
            checks++;
            if (dout !== exp) begin
                fails++;
                $display("FAIL %s: dout=%h expected %h", tag, dout, exp);
            end
        end
        @(posedge clk);
        model_edge(r, l, m, c, ia, oa);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(PERIOD*200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, "R8 reset");
        chk_on = 1'b1;
        // R8: reset broadcast, strobes ignored while held
        step(1, 1, 1, 1, 9, 4, "R8 reset hold");
        step(1, 0, 0, 1, 40, 0, "R8 reset hold");
        idle(2, "R8 broadcast after release");
        // R9: low-half pass-through
        step(0, 0, 0, 1, 0, 0, "R9 pass low");
        idle(3, "R9 pass low");
        step(0, 0, 0, 1, 0, 0, "R10 second cfg copies");
        idle(2, "R9 pass low kept");
        // R9: high-half pass-through
        step(1, 0, 0, 0, 0, 0, "R8 reset");
        step(0, 0, 0, 0, 0, 0, "R8 reset released");
        step(0, 0, 0, 1, 32, 0, "R9 pass high");
        idle(3, "R9 pass high");
        // R2/R3/R4: staged writes without configure
        step(0, 1, 0, 0, 63, 0, "R3 load");
        step(0, 1, 0, 0, 5, 31, "R2 load top output");
        step(0, 1, 0, 0, 17, 12, "R3 load");
        step(0, 1, 0, 0, 18, 12, "R3 load follows");
        idle(3, "R4 no cfg");
        // R5: configure, held two cycles
        step(0, 0, 0, 1, 0, 0, "R5 cfg");
        step(0, 0, 0, 1, 0, 0, "R5 cfg held");
        idle(3, "R5 kept after cfg");
        // R1: multicast of input 7
        for (int o = 0; o < 8; o++) step(0, 1, 0, 0, 7, o * 4, "R1 multicast load");
        step(0, 0, 0, 1, 0, 0, "R1 multicast cfg");
        idle(3, "R1 multicast");
        // R7: monitor write ignores out_addr and load
        step(0, 0, 1, 0, 44, 3, "R7 mon write");
        idle(2, "R7 mon pending only");
        step(0, 0, 0, 1, 0, 0, "R7 mon cfg");
        idle(2, "R7 mon active");
        // R6: load and cfg together
        step(0, 1, 0, 1, 50, 20, "R6 load with cfg");
        idle(2, "R6 routed");
        // R10: write before first cfg disarms pass-through
        step(1, 0, 0, 0, 0, 0, "R8 reset");
        step(0, 1, 0, 0, 33, 9, "R10 load after reset");
        step(0, 0, 0, 1, 32, 0, "R10 normal cfg");
        idle(3, "R10 no pass-through");
        step(1, 0, 0, 0, 0, 0, "R8 reset");
        step(0, 0, 1, 0, 21, 0, "R10 mon after reset");
        step(0, 0, 0, 1, 0, 0, "R10 normal cfg");
        idle(3, "R10 no pass-through");
        // random mix
        for (int i = 0; i < 600; i++)
            step(($urandom % 60) == 0, ($urandom % 3) == 0, ($urandom % 9) == 0,
                 ($urandom % 5) == 0, int'($urandom % 64), int'($urandom % 32),
                 "R1 random mix");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule